// File: doc/BRIEF.md
# Strobe-Ordered Address Rebuilder for Static RAM

This block lets a controller built for multiplexed dynamic memory drive a plain static RAM. The controller puts half of a word address on a narrow shared bus, announces it with a falling row strobe, then puts the other half on the same wires and announces it with a falling column strobe. The block watches the order of those strobe edges and keeps each half in its own register. It joins the two halves into one flat 18-bit address and drives the chip-enable, output-enable and write-enable of a 256K x 16 array. The same pins can drive two 256K x 8 banks wired in parallel, sharing address and strobes.

All strobes from the controller are asynchronous to the block. They are sampled on a local clock that is much faster than the strobes and passed through synchronisers before any decision is made. If the column strobe falls before the row strobe, the cycle is a refresh: no address is captured and the RAM is not selected. A row phase that ends without a column phase is dropped without any RAM access. Write data and the write flag are taken when the column half is captured. Read data from the RAM is registered while the read window is open.

Top module: `mux_sram_bridge`

## Requirements
- R1: After reset, sramCeN, sramOeN and sramWeN are all high and sramAddr is zero.
- R2: The value on muxAddr while rasN is low and casN is still high becomes sramAddr[17:9].
- R3: The value on muxAddr after casN falls, with rasN held low from a captured row, becomes sramAddr[8:0]. sramCeN does not go low before that capture.
- R4: In a read (weN high when casN falls), sramCeN and sramOeN are low and sramWeN is high once the column is captured. rdData then follows sramRdData.
- R5: In a write (weN low before casN falls), sramCeN and sramWeN are low and sramOeN is high once the column is captured. sramWrData shows the wrData value present when casN fell.
- R6: If casN falls before rasN, no address half is captured. sramAddr keeps its value, and sramCeN stays high for the whole cycle.
- R7: If rasN rises while casN never fell, sramCeN stays high. The upper half holds the newly captured row and the lower half is unchanged.
- R8: Within five clocks of rasN rising, sramCeN, sramOeN and sramWeN are all high again, and sramAddr is unchanged.
- R9: Changes on muxAddr and wrData after the column capture do not change sramAddr or sramWrData during the access.
- R10: Reads and writes issued back to back each reach the array at their own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| muxAddr | input | 9 | Shared row/column address bus |
| rasN | input | 1 | Row strobe, active low, asynchronous |
| casN | input | 1 | Column strobe, active low, asynchronous |
| weN | input | 1 | Write flag from controller, active low |
| wrData | input | 16 | Write data from controller |
| sramRdData | input | 16 | Data read back from the static RAM |
| sramAddr | output | 18 | Flat word address, row half on top |
| sramCeN | output | 1 | RAM chip enable, active low |
| sramOeN | output | 1 | RAM output enable, active low |
| sramWeN | output | 1 | RAM write enable, active low |
| sramWrData | output | 16 | Data presented to the RAM on writes |
| rdData | output | 16 | Registered read data for the controller |

## Verification
The bench sends a refresh cycle with the column strobe first. A design that checks only for a low row strobe would load a row address and select the RAM there. It also sends a row phase that ends without a column phase. A design that arms the column capture without the row phase, or selects the RAM on the row phase alone, would pulse the chip enable there. The bench moves the multiplexed bus and the write data during an open access, which exposes a column register that keeps loading. Back-to-back read and write cycles show whether the write flag or the end of the enable window carries over from one cycle to the next.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int MUX_W  = 9;
  localparam int ADDR_W = 2 * MUX_W;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic rowLoad;
    logic colLoad;
    logic rdLoad;
  } strobe_t;
endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '1;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    rasN,
  input  logic    casN,
  input  logic    weN,
  output strobe_t stb,
  output logic    ceN,
  output logic    oeN,
  output logic    weOutN
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW_SMP, ST_ROW_HELD, ST_COL_SMP, ST_ACCESS, ST_REFRESH
  } state_t;

  state_t state;
  logic   rasS, casS, weS, rasD, wrMode;
  logic   rasFall;

  bridge_sync #(.STAGES(SYNC_STAGES), .W(3)) uSync (
    .clk (clk),
    .rstN(rstN),
    .d   ({rasN, casN, weN}),
    .q   ({rasS, casS, weS})
  );

  assign rasFall = rasD && !rasS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      rasD   <= 1'b1;
      wrMode <= 1'b0;
    end else begin
      rasD <= rasS;
      unique case (state)
        ST_IDLE:     if (rasFall) state <= casS ? ST_ROW_SMP : ST_REFRESH;
        ST_REFRESH:  if (rasS) state <= ST_IDLE;
        ST_ROW_SMP:  state <= ST_ROW_HELD;
        ST_ROW_HELD: begin
          if (rasS)       state <= ST_IDLE;
          else if (!casS) state <= ST_COL_SMP;
        end
        ST_COL_SMP: begin
          state  <= ST_ACCESS;
          wrMode <= !weS;
        end
        ST_ACCESS:   if (rasS) state <= ST_IDLE;
        default:     state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.rowLoad = (state == ST_ROW_SMP);
    stb.colLoad = (state == ST_COL_SMP);
    stb.rdLoad  = (state == ST_ACCESS) && !wrMode;
    ceN         = (state != ST_ACCESS);
    oeN         = !((state == ST_ACCESS) && !wrMode);
    weOutN      = !((state == ST_ACCESS) && wrMode);
  end

  AST_OE_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(!oeN && !weOutN)); // R4
  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rstN)
    !weOutN |-> !ceN); // R5
  AST_CE_AFTER_COL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ceN) |-> $past(stb.colLoad)); // R3
  AST_REFRESH_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REFRESH) |=> (ceN && !stb.rowLoad && !stb.colLoad)); // R6
  AST_CE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && rasS) |=> ceN); // R8
endmodule

// File: rtl/bridge_dp.sv
module bridge_dp
  import bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [MUX_W-1:0]  muxAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] sramRdData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramWrData,
  output logic [DATA_W-1:0] rdData
);
  logic [MUX_W-1:0]  rowQ, colQ;
  logic [DATA_W-1:0] wrQ, rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ <= '0;
      colQ <= '0;
      wrQ  <= '0;
      rdQ  <= '0;
    end else begin
      if (stb.rowLoad) rowQ <= muxAddr;
      if (stb.colLoad) begin
        colQ <= muxAddr;
        wrQ  <= wrData;
      end
      if (stb.rdLoad) rdQ <= sramRdData;
    end
  end

  assign sramAddr   = {rowQ, colQ};
  assign sramWrData = wrQ;
  assign rdData     = rdQ;

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rowLoad |=> $stable(rowQ)); // R7
  AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.colLoad |=> ($stable(colQ) && $stable(wrQ))); // R9
endmodule

// File: rtl/mux_sram_bridge.sv
module mux_sram_bridge
  import bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MUX_W-1:0]  muxAddr,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] sramRdData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [DATA_W-1:0] sramWrData,
  output logic [DATA_W-1:0] rdData
);
  strobe_t stb;

  bridge_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .rasN  (rasN),
    .casN  (casN),
    .weN   (weN),
    .stb   (stb),
    .ceN   (sramCeN),
    .oeN   (sramOeN),
    .weOutN(sramWeN)
  );

  bridge_dp uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .muxAddr   (muxAddr),
    .wrData    (wrData),
    .sramRdData(sramRdData),
    .sramAddr  (sramAddr),
    .sramWrData(sramWrData),
    .rdData    (rdData)
  );
endmodule

// File: tb/sim_mux_sram_bridge.sv
module sim_mux_sram_bridge;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [8:0]  muxAddr;
  logic        rasN, casN, weN;
  logic [15:0] wrData, sramRdData;
  logic [17:0] sramAddr;
  logic        sramCeN, sramOeN, sramWeN;
  logic [15:0] sramWrData, rdData;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_sram_bridge u0 (
    .clk(clk), .rstN(rstN), .muxAddr(muxAddr), .rasN(rasN), .casN(casN),
    .weN(weN), .wrData(wrData), .sramRdData(sramRdData), .sramAddr(sramAddr),
    .sramCeN(sramCeN), .sramOeN(sramOeN), .sramWeN(sramWeN),
    .sramWrData(sramWrData), .rdData(rdData)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic endCycle(input logic [17:0] expAddr);
    rasN = 1'b1; casN = 1'b1; weN = 1'b1;
    step(5);
    chk(sramCeN && sramOeN && sramWeN, "R8 strobes idle",
        {sramCeN, sramOeN, sramWeN}, 3'b111);
    chk(sramAddr == expAddr, "R8 addr held", sramAddr, expAddr);
    step(3);
  endtask

  task automatic doRead(input logic [8:0] row, input logic [8:0] col,
                        input logic [15:0] mem);
    logic earlyCe = 1'b0;
    sramRdData = mem;
    muxAddr = row; rasN = 1'b0;
    for (int i = 0; i < 6; i++) begin step(1); if (!sramCeN) earlyCe = 1'b1; end
    chk(!earlyCe, "R3 no CE before column", earlyCe, 0);
    chk(sramAddr[17:9] == row, "R2 row half", sramAddr[17:9], row);
    muxAddr = col; casN = 1'b0;
    step(8);
    chk(sramAddr == {row, col}, "R3 full address", sramAddr, {row, col});
    chk(!sramCeN && !sramOeN && sramWeN, "R4 read strobes",
        {sramCeN, sramOeN, sramWeN}, 3'b001);
    chk(rdData == mem, "R4 read data", rdData, mem);
    endCycle({row, col});
  endtask

  task automatic doWrite(input logic [8:0] row, input logic [8:0] col,
                         input logic [15:0] dat, input logic disturb);
    muxAddr = row; rasN = 1'b0;
    step(6);
    weN = 1'b0; wrData = dat;
    step(1);
    muxAddr = col; casN = 1'b0;
    step(8);
    chk(sramAddr == {row, col}, "R5 write address", sramAddr, {row, col});
    chk(!sramCeN && sramOeN && !sramWeN, "R5 write strobes",
        {sramCeN, sramOeN, sramWeN}, 3'b010);
    chk(sramWrData == dat, "R5 write data", sramWrData, dat);
    if (disturb) begin
      muxAddr = ~col; wrData = ~dat;
      step(4);
      chk(sramAddr == {row, col}, "R9 addr ignores bus", sramAddr, {row, col});
      chk(sramWrData == dat, "R9 data ignores bus", sramWrData, dat);
      chk(!sramWeN, "R9 write still open", sramWeN, 0);
    end
    endCycle({row, col});
  endtask

  task automatic doRefresh(input logic [17:0] prevAddr);
    logic seenCe = 1'b0;
    muxAddr = 9'h0AA; casN = 1'b0;
    step(4);
    rasN = 1'b0;
    for (int i = 0; i < 12; i++) begin step(1); if (!sramCeN) seenCe = 1'b1; end
    chk(!seenCe, "R6 refresh no CE", seenCe, 0);
    chk(sramAddr == prevAddr, "R6 refresh addr kept", sramAddr, prevAddr);
    endCycle(prevAddr);
  endtask

  task automatic doAbandon(input logic [8:0] row, input logic [8:0] oldCol);
    logic seenCe = 1'b0;
    muxAddr = row; rasN = 1'b0;
    for (int i = 0; i < 6; i++) begin step(1); if (!sramCeN) seenCe = 1'b1; end
    rasN = 1'b1;
    for (int i = 0; i < 6; i++) begin step(1); if (!sramCeN) seenCe = 1'b1; end
    chk(!seenCe, "R7 abandoned no CE", seenCe, 0);
    chk(sramAddr == {row, oldCol}, "R7 row kept col unchanged", sramAddr, {row, oldCol});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rstN = 1'b0; muxAddr = '0; rasN = 1'b1; casN = 1'b1; weN = 1'b1;
    wrData = '0; sramRdData = '0;
    step(3);
    chk(sramCeN && sramOeN && sramWeN, "R1 reset strobes",
        {sramCeN, sramOeN, sramWeN}, 3'b111);
    chk(sramAddr == 18'h0, "R1 reset address", sramAddr, 0);
    rstN = 1'b1;
    step(3);
    doRead(9'h1F3, 9'h04C, 16'hBEEF);
    doWrite(9'h155, 9'h0AA, 16'h1234, 1'b1);
    doRefresh({9'h155, 9'h0AA});
    doAbandon(9'h0C7, 9'h0AA);
    // R10: back-to-back read then write then read
    doRead(9'h000, 9'h1FF, 16'h0F0F);
    doWrite(9'h1FF, 9'h000, 16'hA5C3, 1'b0);
    doRead(9'h101, 9'h0FE, 16'h7E81);
    chk(rdData == 16'h7E81, "R10 last read data", rdData, 16'h7E81);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule